// File: doc/BRIEF.md
# CPU External Interrupt Arbiter

This block sits next to a simple in-order CPU core. It decides which external interrupt source the core takes, and when. There are three sources, in fixed priority. A system-management request ranks highest. A non-maskable request comes next; it is raised by software through a configuration bit, because no pin exists for it. The maskable interrupt level ranks lowest. The core signals each instruction boundary, each IRET that retires, and whether it is halted. The arbiter answers with a one-cycle take pulse carrying a class code and an 8-bit vector.

For a maskable interrupt, the arbiter first runs a request/acknowledge handshake with an external interrupt controller. The controller returns the vector along with the acknowledge, and the arbiter delivers that vector at a later boundary.

The arbiter tracks whether a non-maskable handler is running. While one is running it blocks further non-maskable requests and keeps at most one pending rising edge. Maskable interrupts may still nest inside that handler. When the core is halted, the arbiter raises a wake signal if a source is present that the core could take.

Top module: `cpu_irq_arbiter`

## Requirements
- R1: A synchronous active-low reset clears all outputs to 0. It also discards any pending system-management or non-maskable edge, clears the non-maskable in-service state and abandons an outstanding acknowledge handshake.
- R2: When several sources are ready at one boundary, exactly one is taken. System-management wins over non-maskable, which wins over maskable. A maskable acknowledge is not started at a boundary where a higher source is ready.
- R3: A non-maskable take reports class code 2 and vector `NMI_VEC` (default 2). It raises no acknowledge request.
- R4: Non-maskable requests are detected on the rising edge of the request bit. A bit held high yields exactly one take.
- R5: After a non-maskable take, further non-maskable takes are blocked until `iret_done` is seen. Rising edges in that window store a single pending request, taken at the first boundary after the IRET. Any further edges in that window are lost.
- R6: A maskable acknowledge starts only in a cycle where `insn_bnd`, `if_flag` and `intr_lvl` are all 1. `iack_req` goes high in the next cycle.
- R7: `iack_req` stays high until `iack_ack` is sampled high, at which point `iack_vec` is captured. The next boundary after that delivers a take with class code 3 and the captured vector.
- R8: While a non-maskable handler is in service, a maskable interrupt with the enable flag set is still acknowledged and taken.
- R9: `wake` is 1 in the cycle after one in which `halted` was 1 and any of these held: a system-management edge was pending; `intr_lvl` and `if_flag` were both 1; a non-maskable edge was pending with no handler in service. A non-maskable edge pending during a handler does not wake the core.
- R10: `take` is a registered one-cycle pulse. It appears in the cycle after the boundary cycle that granted it. When `take` is 0, the class code is 0 (none) and the vector is 0.
- R11: A system-management request is stored on its rising edge. It is taken at the next boundary with class code 1 and vector 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smi_req | input | 1 | System-management request level, active high |
| intr_lvl | input | 1 | Maskable interrupt level from the controller |
| nmi_sw | input | 1 | Software non-maskable request bit from the configuration register |
| if_flag | input | 1 | Interrupt-enable flag of the core |
| insn_bnd | input | 1 | Strobe, 1 in a cycle that is an instruction boundary |
| iret_done | input | 1 | Strobe, 1 when an IRET retires |
| halted | input | 1 | Core is in the halt state |
| iack_ack | input | 1 | Controller acknowledge, vector valid with it |
| iack_vec | input | VEC_W | Vector returned by the controller |
| iack_req | output | 1 | Acknowledge request to the controller |
| take | output | 1 | One-cycle take pulse to the core |
| take_class | output | 2 | 0 none, 1 system-management, 2 non-maskable, 3 maskable |
| take_vec | output | VEC_W | Vector of the taken interrupt |
| wake | output | 1 | Resume request for a halted core |

## Verification
The bench builds the arbiter with its defaults: an 8-bit vector and a non-maskable vector of 2. This makes the full range of controller vectors usable, and every vector the bench returns stands apart from the fixed codes 0 and 2. A cycle-by-cycle table drives the nesting and priority sequences. It covers a held non-maskable bit, repeated edges inside a handler, a maskable interrupt nested inside that handler, and all three sources arriving at once. Directed steps then reset the block in the middle of a handler with an edge pending and a handshake outstanding.

// File: rtl/irq_arb_pkg.sv
// Shared types for the interrupt arbiter.
// Assumes: class encoding is visible at the top-level ports and fixed.
package irq_arb_pkg;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_SMI  = 2'd1,
        CLS_NMI  = 2'd2,
        CLS_INTR = 2'd3
    } irq_class_e;

    typedef enum logic [1:0] {
        ACK_IDLE = 2'd0,
        ACK_WAIT = 2'd1,
        ACK_HELD = 2'd2
    } ack_state_e;

endpackage

// File: rtl/irq_edge_latch.sv
// Rising-edge detector with a one-deep pending bit.
// Assumes: req_in is synchronous to clk. A new edge wins over consume in
// the same cycle, so an edge arriving at the moment of a take is kept.
module irq_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic req_in,
    input  logic consume,
    output logic pend
);

    logic prev_q;

    // Track the previous level and hold one pending edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            prev_q <= req_in;
            if (req_in && !prev_q) begin
                pend <= 1'b1;
            end else if (consume) begin
                pend <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irq_ack_fsm.sv
// Request/acknowledge handshake with the external interrupt controller.
// Assumes: the controller presents its vector in the same cycle as ack.
// The captured vector is held until the core consumes it at a boundary.
module irq_ack_fsm #(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             consume,
    input  logic             iack_ack,
    input  logic [VEC_W-1:0] iack_vec,
    output logic             iack_req,
    output logic             idle,
    output logic             ready,
    output logic [VEC_W-1:0] vec
);

    import irq_arb_pkg::*;

    ack_state_e state_q;

    // Advance the handshake and capture the returned vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ACK_IDLE;
            vec     <= '0;
        end else begin
            unique case (state_q)
                ACK_IDLE: if (start) state_q <= ACK_WAIT;
                ACK_WAIT: if (iack_ack) begin
                    state_q <= ACK_HELD;
                    vec     <= iack_vec;
                end
                ACK_HELD: if (consume) state_q <= ACK_IDLE;
                default:  state_q <= ACK_IDLE;
            endcase
        end
    end

    // Decode status outputs from the state.
    always_comb begin
        iack_req = (state_q == ACK_WAIT);
        idle     = (state_q == ACK_IDLE);
        ready    = (state_q == ACK_HELD);
    end

endmodule

// File: rtl/irq_prio_sel.sv
// Fixed-priority grant at an instruction boundary. System-management ranks
// first, then non-maskable (unless a handler is in service), then a
// maskable interrupt whose vector is ready.
// Assumes: all inputs are registered state or core strobes; purely combinational.
module irq_prio_sel (
    input  logic bnd,
    input  logic smi_pend,
    input  logic nmi_pend,
    input  logic nmi_busy,
    input  logic intr_ready,
    input  logic intr_raise,
    input  logic ack_idle,
    output logic g_smi,
    output logic g_nmi,
    output logic g_intr,
    output logic start_ack
);

    logic nmi_ok;
    logic no_high;

    // Resolve one winner per boundary and gate the start of a new handshake.
    always_comb begin
        nmi_ok    = nmi_pend && !nmi_busy;
        no_high   = !smi_pend && !nmi_ok;
        g_smi     = bnd && smi_pend;
        g_nmi     = bnd && !smi_pend && nmi_ok;
        g_intr    = bnd && no_high && intr_ready;
        start_ack = bnd && no_high && ack_idle && intr_raise;
    end

endmodule

// File: rtl/cpu_irq_arbiter.sv
// Interrupt arbiter top. It stores edges of the system-management and
// software non-maskable requests, runs the maskable acknowledge handshake,
// picks one source per boundary, tracks non-maskable in-service state and
// raises wake for a halted core.
// Assumes: all inputs are synchronous to clk. Any IRET retiring ends the
// non-maskable blocking window.
module cpu_irq_arbiter #(
    parameter int VEC_W   = 8,
    parameter int NMI_VEC = 2,
    parameter int SMI_VEC = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smi_req,
    input  logic             intr_lvl,
    input  logic             nmi_sw,
    input  logic             if_flag,
    input  logic             insn_bnd,
    input  logic             iret_done,
    input  logic             halted,
    input  logic             iack_ack,
    input  logic [VEC_W-1:0] iack_vec,
    output logic             iack_req,
    output logic             take,
    output logic [1:0]       take_class,
    output logic [VEC_W-1:0] take_vec,
    output logic             wake
);

    import irq_arb_pkg::*;

    localparam int NSRC = 2;
    localparam int SRC_SMI = 0;
    localparam int SRC_NMI = 1;
    localparam logic [VEC_W-1:0] NMI_V = VEC_W'(NMI_VEC);
    localparam logic [VEC_W-1:0] SMI_V = VEC_W'(SMI_VEC);

    logic [NSRC-1:0] src_lvl;
    logic [NSRC-1:0] src_take;
    logic [NSRC-1:0] src_pend;
    logic            nmi_busy;
    logic            g_smi, g_nmi, g_intr, start_ack;
    logic            ack_idle, intr_ready;
    logic [VEC_W-1:0] intr_vec;

    // Map the edge-triggered sources onto the latch array.
    always_comb begin
        src_lvl[SRC_SMI]  = smi_req;
        src_lvl[SRC_NMI]  = nmi_sw;
        src_take[SRC_SMI] = g_smi;
        src_take[SRC_NMI] = g_nmi;
    end

    for (genvar gi = 0; gi < NSRC; gi++) begin : g_edge
        irq_edge_latch u_latch (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_in  (src_lvl[gi]),
            .consume (src_take[gi]),
            .pend    (src_pend[gi])
        );
    end

    irq_ack_fsm #(.VEC_W(VEC_W)) u_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_ack),
        .consume  (g_intr),
        .iack_ack (iack_ack),
        .iack_vec (iack_vec),
        .iack_req (iack_req),
        .idle     (ack_idle),
        .ready    (intr_ready),
        .vec      (intr_vec)
    );

    irq_prio_sel u_sel (
        .bnd        (insn_bnd),
        .smi_pend   (src_pend[SRC_SMI]),
        .nmi_pend   (src_pend[SRC_NMI]),
        .nmi_busy   (nmi_busy),
        .intr_ready (intr_ready),
        .intr_raise (intr_lvl && if_flag),
        .ack_idle   (ack_idle),
        .g_smi      (g_smi),
        .g_nmi      (g_nmi),
        .g_intr     (g_intr),
        .start_ack  (start_ack)
    );

    // Non-maskable in-service flag: set on take, cleared by a retiring IRET.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_busy <= 1'b0;
        end else if (g_nmi) begin
            nmi_busy <= 1'b1;
        end else if (iret_done) begin
            nmi_busy <= 1'b0;
        end
    end

    // Register the take pulse, its class and vector, and the wake request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take       <= 1'b0;
            take_class <= CLS_NONE;
            take_vec   <= '0;
            wake       <= 1'b0;
        end else begin
            take <= g_smi || g_nmi || g_intr;
            if (g_smi) begin
                take_class <= CLS_SMI;
                take_vec   <= SMI_V;
            end else if (g_nmi) begin
                take_class <= CLS_NMI;
                take_vec   <= NMI_V;
            end else if (g_intr) begin
                take_class <= CLS_INTR;
                take_vec   <= intr_vec;
            end else begin
                take_class <= CLS_NONE;
                take_vec   <= '0;
            end
            wake <= halted && (src_pend[SRC_SMI] || (intr_lvl && if_flag) ||
                               (src_pend[SRC_NMI] && !nmi_busy));
        end
    end

endmodule

// File: rtl/cpu_irq_arbiter_chk.sv
// Port-level checker for the interrupt arbiter, bound to every instance.
// Assumes: it sees only the top-level ports. Its own small state tracks
// the in-service window and the last acknowledged vector.
module cpu_irq_arbiter_chk #(
    parameter int VEC_W   = 8,
    parameter int NMI_VEC = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             intr_lvl,
    input logic             if_flag,
    input logic             insn_bnd,
    input logic             iret_done,
    input logic             halted,
    input logic             iack_ack,
    input logic [VEC_W-1:0] iack_vec,
    input logic             iack_req,
    input logic             take,
    input logic [1:0]       take_class,
    input logic [VEC_W-1:0] take_vec,
    input logic             wake
);

    logic             m_busy;
    logic [VEC_W-1:0] m_vec;

    // Model the in-service window and the captured vector from the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 1'b0;
            m_vec  <= '0;
        end else begin
            if (iret_done) m_busy <= 1'b0;
            else if (take && take_class == 2'd2) m_busy <= 1'b1;
            if (iack_req && iack_ack) m_vec <= iack_vec;
        end
    end

    a_r3_nmi_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_class == 2'd2) |-> take_vec == VEC_W'(NMI_VEC));

    a_r11_smi_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_class == 2'd1) |-> take_vec == '0);

    a_r5_one_nmi_per_window: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_class == 2'd2) |-> !m_busy);

    a_r6_req_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iack_req) |-> $past(insn_bnd && if_flag && intr_lvl));

    a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (iack_req && !iack_ack) |=> iack_req);

    a_r7_vector_delivered: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_class == 2'd3) |-> take_vec == m_vec);

    a_r10_take_follows_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $past(insn_bnd));

    a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !take |-> (take_class == 2'd0 && take_vec == '0));

    a_r9_wake_needs_halt: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> $past(halted));

endmodule

bind cpu_irq_arbiter cpu_irq_arbiter_chk #(.VEC_W(VEC_W), .NMI_VEC(NMI_VEC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .intr_lvl   (intr_lvl),
    .if_flag    (if_flag),
    .insn_bnd   (insn_bnd),
    .iret_done  (iret_done),
    .halted     (halted),
    .iack_ack   (iack_ack),
    .iack_vec   (iack_vec),
    .iack_req   (iack_req),
    .take       (take),
    .take_class (take_class),
    .take_vec   (take_vec),
    .wake       (wake)
);

// File: tb/tb_cpu_irq_arbiter.sv
`timescale 1ns/1ps
module tb_cpu_irq_arbiter;

    localparam int VEC_W = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic smi_req, intr_lvl, nmi_sw, if_flag, insn_bnd, iret_done, halted, iack_ack;
    logic [VEC_W-1:0] iack_vec;
    logic iack_req, take, wake;
    logic [1:0] take_class;
    logic [VEC_W-1:0] take_vec;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cpu_irq_arbiter #(.VEC_W(VEC_W)) dut (
        .clk(clk), .rst_n(rst_n), .smi_req(smi_req), .intr_lvl(intr_lvl),
        .nmi_sw(nmi_sw), .if_flag(if_flag), .insn_bnd(insn_bnd),
        .iret_done(iret_done), .halted(halted), .iack_ack(iack_ack),
        .iack_vec(iack_vec), .iack_req(iack_req), .take(take),
        .take_class(take_class), .take_vec(take_vec), .wake(wake)
    );

    // stim bits: smi intr nmi if bnd iret halt ack
    typedef struct packed {
        logic [7:0] stim;
        logic [7:0] avec;
        logic       e_take;
        logic [1:0] e_cls;
        logic [7:0] e_vec;
        logic       e_req;
        logic       e_wake;
    } row_t;

    localparam int NROWS = 45;
    localparam row_t TBL [NROWS] = '{
        '{8'b00000000, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0}, // 0  R1 idle
        '{8'b01001000, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0}, // 1  R6 masked
        '{8'b01010000, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0}, // 2  R6 no boundary
        '{8'b01011000, 8'h00, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0}, // 3  R6 start
        '{8'b00010000, 8'h00, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0}, // 4  R7 held
        '{8'b00010001, 8'h41, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0}, // 5  R7 ack
        '{8'b00000000, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0}, // 6
        '{8'b00001000, 8'h00, 1'b1, 2'd3, 8'h41, 1'b0, 1'b0}, // 7  R7 R10 deliver
        '{8'b00001000, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0}, // 8  R10 single pulse
        '{8'b00100000, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0}, // 9  nmi edge
        '{8'b00101000, 8'h00, 1'b1, 2'd2, 8'h02, 1'b0, 1'b0}, // 10 R3 nmi take
        '{8'b00101000, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0}, // 11 R4 held level
        '{8'b00000000, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0}, // 12
        '{8'b00100000, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0}, // 13 edge in handler
        '{8'b00001000, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0}, // 14 R5 blocked
        '{8'b00100000, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0}, // 15 second edge
        '{8'b01011000, 8'h00, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0}, // 16 R8 nested start
        '{8'b00010001, 8'h77, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0}, // 17 R8 ack
        '{8'b00001000, 8'h00, 1'b1, 2'd3, 8'h77, 1'b0, 1'b0}, // 18 R8 nested take
        '{8'b00000100, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0}, // 19 iret
        '{8'b00001000, 8'h00, 1'b1, 2'd2, 8'h02, 1'b0, 1'b0}, // 20 R5 stored edge
        '{8'b00000100, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0}, // 21 iret
        '{8'b00001000, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0}, // 22 R5 only one
        '{8'b11110000, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0}, // 23 all arrive
        '{8'b11111000, 8'h00, 1'b1, 2'd1, 8'h00, 1'b0, 1'b0}, // 24 R2 R11 smi first
        '{8'b11111000, 8'h00, 1'b1, 2'd2, 8'h02, 1'b0, 1'b0}, // 25 R2 nmi next
        '{8'b11111000, 8'h00, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0}, // 26 R2 intr last
        '{8'b00000001, 8'h99, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0}, // 27 ack
        '{8'b00001000, 8'h00, 1'b1, 2'd3, 8'h99, 1'b0, 1'b0}, // 28 R2 intr take
        '{8'b00000100, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0}, // 29 iret
        '{8'b00100000, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0}, // 30 nmi edge
        '{8'b00100010, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1}, // 31 R9 nmi wakes
        '{8'b00101000, 8'h00, 1'b1, 2'd2, 8'h02, 1'b0, 1'b0}, // 32 take nmi
        '{8'b00000010, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0}, // 33 halted
        '{8'b00100010, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0}, // 34 edge in handler
        '{8'b00100010, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0}, // 35 R9 no nmi wake
        '{8'b01000010, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0}, // 36 R9 masked
        '{8'b01010010, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1}, // 37 R9 intr wakes
        '{8'b10000010, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0}, // 38 smi edge
        '{8'b10000010, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1}, // 39 R9 R11 smi wakes
        '{8'b00001000, 8'h00, 1'b1, 2'd1, 8'h00, 1'b0, 1'b0}, // 40 R11 smi take
        '{8'b00001000, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0}, // 41 R5 still blocked
        '{8'b00000100, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0}, // 42 iret
        '{8'b00001000, 8'h00, 1'b1, 2'd2, 8'h02, 1'b0, 1'b0}, // 43 R5 after iret
        '{8'b00000100, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0}  // 44 iret
    };

    task automatic drive(input logic [7:0] s, input logic [7:0] v);
        {smi_req, intr_lvl, nmi_sw, if_flag, insn_bnd, iret_done, halted, iack_ack} = s;
        iack_vec = v;
    endtask

    task automatic step(input logic [7:0] s, input logic [7:0] v);
        drive(s, v);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic e_take, input logic [1:0] e_cls,
                         input logic [7:0] e_vec, input logic e_req, input logic e_wake);
        n_checks++;
        if (take !== e_take || take_class !== e_cls || take_vec !== e_vec ||
            iack_req !== e_req || wake !== e_wake) begin
            n_fail++;
            $display("FAIL %s: actual take=%b cls=%0d vec=%h req=%b wake=%b expected take=%b cls=%0d vec=%h req=%b wake=%b",
                     tag, take, take_class, take_vec, iack_req, wake,
                     e_take, e_cls, e_vec, e_req, e_wake);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(8'h00, 8'h00);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset state", 1'b0, 2'd0, 8'h00, 1'b0, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NROWS; i++) begin
            step(TBL[i].stim, TBL[i].avec);
            check($sformatf("table row %0d", i), TBL[i].e_take, TBL[i].e_cls,
                  TBL[i].e_vec, TBL[i].e_req, TBL[i].e_wake);
        end

        // R1: reset during a handler, with an edge pending and a request out.
        step(8'b00100000, 8'h00);                 // nmi edge
        step(8'b00101000, 8'h00);                 // take nmi, in service
        check("R1 setup nmi take", 1'b1, 2'd2, 8'h02, 1'b0, 1'b0);
        step(8'b00000000, 8'h00);
        step(8'b00100000, 8'h00);                 // pending edge stored
        step(8'b01011000, 8'h00);                 // maskable request out
        check("R1 setup request", 1'b0, 2'd0, 8'h00, 1'b1, 1'b0);
        rst_n = 1'b0;
        step(8'b00000010, 8'h00);
        check("R1 outputs cleared", 1'b0, 2'd0, 8'h00, 1'b0, 1'b0);
        rst_n = 1'b1;
        step(8'b00001010, 8'h00);                 // boundary, halted
        check("R1 pending edge dropped", 1'b0, 2'd0, 8'h00, 1'b0, 1'b0);
        step(8'b00001001, 8'h5a);                 // ack with no request
        check("R1 handshake abandoned", 1'b0, 2'd0, 8'h00, 1'b0, 1'b0);
        step(8'b00100000, 8'h00);                 // fresh edge
        step(8'b00101000, 8'h00);
        check("R1 in-service cleared", 1'b1, 2'd2, 8'h02, 1'b0, 1'b0);
        step(8'b00000100, 8'h00);

        // R6 with R7: a long wait for ack keeps the request up.
        step(8'b01011000, 8'h00);
        for (int k = 0; k < 5; k++) begin
            step(8'b00000000, 8'h00);
            check("R7 request held", 1'b0, 2'd0, 8'h00, 1'b1, 1'b0);
        end
        step(8'b00000001, 8'hff);
        step(8'b00001000, 8'h00);
        check("R7 vector ff", 1'b1, 2'd3, 8'hff, 1'b0, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule